// File: doc/BRIEF.md
# Compare-and-branch program counter

This block supplies the instruction address for a small 8-bit accumulator machine and makes the conditional branch decision itself. On each clock the 4-bit address steps up by one, holds, or takes a 4-bit jump target. The target is the low nibble of the current instruction word.

A magnitude comparator sits beside the counter. It compares the two 8-bit operand registers as unsigned values. When a latch control is high, it stores their relation as a 2-bit code. A later branch instruction tests that stored code.

The branch opcodes carry the relation they test in their two low bits. The taken decision is therefore a check that the two high opcode bits are zero, plus an equality match against the stored code. The decision drives an active-low load strobe. The strobe is also brought out at the block's edge.

A separate unconditional jump input forces the load whatever the opcode is.

Top module: `cmp_branch_pc`

## Requirements
- R1: Bits 7:4 of the instruction word are the opcode and bits 3:0 are the operand; for a branch the operand is the 4-bit target address.
- R2: The comparator treats both operands as unsigned and encodes the relation as 01 for A<B, 11 for A=B and 10 for A>B. The code is stored at a clock edge when the latch input is high and held otherwise. Reset clears it to 00.
- R3: Opcodes 0001, 0011 and 0010 drive the load strobe low (combinationally) exactly when their two low bits equal the stored relation code.
- R4: Any opcode whose two high bits are not 00 leaves the load strobe high unless the forced jump is asserted.
- R5: Opcode 0000 never drives the load strobe low. This includes the state after reset, when the stored code is 00.
- R6: When the load strobe is low, the address takes the operand's low 4 bits on the next clock edge. Once the strobe is released, counting continues upward from that value.
- R7: With the load strobe high and the count enable high, the address advances by one per clock and wraps from 1111 to 0000.
- R8: With the load strobe high and the count enable low, the address holds.
- R9: Synchronous active-high reset clears the address to 0000 and takes priority over a load. A load takes priority over counting and happens even when the count enable is low.
- R10: The forced jump input drives the load strobe low for every opcode and stored relation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 8 | Current instruction word (opcode in 7:4, operand in 3:0) |
| opa_i | input | 8 | Operand register A value |
| opb_i | input | 8 | Operand register B value |
| rel_latch_i | input | 1 | Store the A-versus-B relation at the next edge |
| cnt_en_i | input | 1 | Advance the address when no load is taken |
| jmp_force_i | input | 1 | Unconditional jump to the operand |
| pc_o | output | 4 | Current instruction address (registered) |
| load_n_o | output | 1 | Active-low load strobe |
| rel_o | output | 2 | Stored relation code |

## Verification
The comparator is driven with every value of A against sixteen values of B spread across the range. This separates below, equal and above at both ends of the range, and exercises the unsigned treatment of values with the top bit set.

After each store, the operands are changed with the latch low. A relation that stays put shows that the code is held rather than followed.

For each of the three stored relations, all sixteen opcodes are applied with the forced jump and the count enable each on and off. This tells matching branch opcodes apart from mismatching ones, from opcodes with a nonzero prefix and from opcode 0000. It also separates a load from an increment and from a hold.

Short directed sequences cover reset against a forced jump, a load with counting disabled, and the wrap from 1111.

// File: rtl/cmp_branch_pkg.sv
package cmp_branch_pkg;
  localparam int REL_W = 2;
  localparam logic [REL_W-1:0] REL_NONE = 2'b00;
  localparam logic [REL_W-1:0] REL_LT   = 2'b01;
  localparam logic [REL_W-1:0] REL_EQ   = 2'b11;
  localparam logic [REL_W-1:0] REL_GT   = 2'b10;
endpackage

// File: rtl/rel_latch.sv
module rel_latch
  import cmp_branch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              latch,
  output logic [REL_W-1:0]  rel_q
);
  logic [REL_W-1:0] rel_d;
  logic             is_lt;
  logic             is_eq;

  // unsigned compare
  always_comb begin
    is_lt = (opa < opb);
    is_eq = (opa == opb);
    if (is_eq)      rel_d = REL_EQ;
    else if (is_lt) rel_d = REL_LT;
    else            rel_d = REL_GT;
  end

  always_ff @(posedge clk) begin
    if (rst)        rel_q <= REL_NONE;
    else if (latch) rel_q <= rel_d;
  end

  // R2: a stored relation is always a real code
  p_latch_valid_r2: assert property (@(posedge clk) disable iff (rst)
    latch |=> (rel_q != REL_NONE));
  // R2: code held while the latch is low
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !latch |=> $stable(rel_q));
  // R2: below-relation from the ports
  p_lt_r2: assert property (@(posedge clk) disable iff (rst)
    (latch && (opa < opb)) |=> (rel_q == REL_LT));
endmodule

// File: rtl/branch_decide.sv
module branch_decide
  import cmp_branch_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OPC_W  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] instr,
  input  logic [REL_W-1:0]  rel,
  input  logic              force_jmp,
  output logic              load_n,
  output logic [ADDR_W-1:0] target
);
  localparam int PFX_W = OPC_W - REL_W;

  logic [OPC_W-1:0] opcode;
  logic [PFX_W-1:0] prefix;
  logic [REL_W-1:0] cond;
  logic             cond_take;

  always_comb begin
    opcode    = instr[DATA_W-1 -: OPC_W];
    prefix    = opcode[OPC_W-1 -: PFX_W];
    cond      = opcode[REL_W-1:0];
    target    = instr[ADDR_W-1:0];
    // code 00 is never produced by the comparator, so it cannot match
    cond_take = (prefix == '0) && (cond == rel) && (rel != REL_NONE);
    load_n    = !(cond_take || force_jmp);
  end

  // R5: opcode zero never branches on its own
  p_zero_no_take_r5: assert property (@(posedge clk) disable iff (rst)
    ((opcode == '0) && !force_jmp) |-> load_n);
  // R4: nonzero prefix never branches on its own
  p_prefix_no_take_r4: assert property (@(posedge clk) disable iff (rst)
    ((prefix != '0) && !force_jmp) |-> load_n);
  // R10: forced jump always loads
  p_force_r10: assert property (@(posedge clk) disable iff (rst)
    force_jmp |-> !load_n);
endmodule

// File: rtl/pc_counter.sv
module pc_counter #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst)         pc <= '0;
    else if (!load_n) pc <= target;
    else if (en)     pc <= pc + ONE;
  end

  // R9: reset clears the address whatever else is asserted
  p_reset_r9: assert property (@(posedge clk)
    rst |=> (pc == '0));
  // R6: load takes the target
  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> (pc == $past(target)));
  // R7: increment with wrap
  p_inc_r7: assert property (@(posedge clk) disable iff (rst)
    (load_n && en) |=> (pc == ADDR_W'($past(pc) + ONE)));
  // R8: hold
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (load_n && !en) |=> $stable(pc));
endmodule

// File: rtl/cmp_branch_pc.sv
module cmp_branch_pc
  import cmp_branch_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OPC_W  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] instr_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              rel_latch_i,
  input  logic              cnt_en_i,
  input  logic              jmp_force_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              load_n_o,
  output logic [REL_W-1:0]  rel_o
);
  logic [REL_W-1:0]  rel_q;
  logic [ADDR_W-1:0] tgt;
  logic              ld_n;

  rel_latch #(.DATA_W(DATA_W)) u_rel (
    .clk   (clk),
    .rst   (rst),
    .opa   (opa_i),
    .opb   (opb_i),
    .latch (rel_latch_i),
    .rel_q (rel_q)
  );

  branch_decide #(.DATA_W(DATA_W), .OPC_W(OPC_W), .ADDR_W(ADDR_W)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .instr     (instr_i),
    .rel       (rel_q),
    .force_jmp (jmp_force_i),
    .load_n    (ld_n),
    .target    (tgt)
  );

  pc_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load_n (ld_n),
    .en     (cnt_en_i),
    .target (tgt),
    .pc     (pc_o)
  );

  assign load_n_o = ld_n;
  assign rel_o    = rel_q;

  // R3: a matching branch opcode with a real stored code loads
  p_match_take_r3: assert property (@(posedge clk) disable iff (rst)
    ((instr_i[DATA_W-1 -: 2] == 2'b00) && (rel_q != REL_NONE) &&
     (instr_i[DATA_W-3 -: 2] == rel_q)) |-> !load_n_o);
endmodule

// File: tb/test_cmp_branch_pc.sv
module test_cmp_branch_pc;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] instr = '0;
  logic [7:0] opa = '0;
  logic [7:0] opb = '0;
  logic       latch = 1'b0;
  logic       en = 1'b0;
  logic       jmp = 1'b0;
  logic [3:0] pc;
  logic       load_n;
  logic [1:0] rel;

  int checks = 0;
  int fails  = 0;
  logic [3:0] exp_pc;

  cmp_branch_pc i_cmp_branch_pc (
    .clk(clk), .rst(rst), .instr_i(instr), .opa_i(opa), .opb_i(opb),
    .rel_latch_i(latch), .cnt_en_i(en), .jmp_force_i(jmp),
    .pc_o(pc), .load_n_o(load_n), .rel_o(rel)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [1:0] rel_of(input int x, input int y);
    if (x == y) return 2'b11;
    if (x < y)  return 2'b01;
    return 2'b10;
  endfunction

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick; tick;
    chk(pc == 4'd0, "R9 reset address", int'(pc), 0);
    chk(rel == 2'b00, "R2 reset relation", int'(rel), 0);
    instr = 8'h05; #1;
    chk(load_n == 1'b1, "R5 opcode 0000 after reset", int'(load_n), 1);
    instr = 8'h07; #1;
    chk(load_n == 1'b1, "R5 opcode 0000 other target", int'(load_n), 1);

    // R9: reset beats a forced jump
    jmp = 1'b1; instr = 8'h0A;
    tick;
    chk(pc == 4'd0, "R9 reset over load", int'(pc), 0);
    rst = 1'b0;
    tick;   // forced load with counting disabled
    chk(pc == 4'd10, "R9 R10 load with enable low", int'(pc), 10);
    jmp = 1'b0; instr = 8'h00;
    tick; tick; tick;
    chk(pc == 4'd10, "R8 hold", int'(pc), 10);

    // R7: wrap
    jmp = 1'b1; instr = 8'h4F; en = 1'b1;
    tick;
    chk(pc == 4'd15, "R6 load 15", int'(pc), 15);
    jmp = 1'b0; instr = 8'h40;
    tick;
    chk(pc == 4'd0, "R7 wrap", int'(pc), 0);
    tick;
    chk(pc == 4'd1, "R6 counting resumes", int'(pc), 1);
    en = 1'b0;
    exp_pc = 4'd1;

    // R2: comparator sweep
    for (int ai = 0; ai < 256; ai++) begin
      for (int bj = 0; bj < 16; bj++) begin
        opa = 8'(ai); opb = 8'(bj * 17); latch = 1'b1;
        tick;
        chk(rel == rel_of(ai, bj * 17), "R2 relation", int'(rel), int'(rel_of(ai, bj * 17)));
      end
      latch = 1'b0; opa = ~opa; opb = 8'(ai);
      tick;
      chk(rel == rel_of(ai, 255), "R2 held with latch low", int'(rel), int'(rel_of(ai, 255)));
    end
    chk(pc == exp_pc, "R8 hold through sweep", int'(pc), int'(exp_pc));

    // R1 R3 R4 R5 R10: branch sweep over opcode, force and enable
    for (int ri = 0; ri < 3; ri++) begin
      logic [1:0] r;
      r = (ri == 0) ? 2'b01 : (ri == 1) ? 2'b11 : 2'b10;
      case (ri)
        0: begin opa = 8'd1; opb = 8'd2; end
        1: begin opa = 8'd5; opb = 8'd5; end
        default: begin opa = 8'd200; opb = 8'd3; end
      endcase
      latch = 1'b1; en = 1'b0; jmp = 1'b0; instr = 8'hF0;
      tick;
      latch = 1'b0;
      chk(rel == r, "R2 set relation", int'(rel), int'(r));
      for (int opc = 0; opc < 16; opc++) begin
        for (int f = 0; f < 2; f++) begin
          for (int e = 0; e < 2; e++) begin
            logic [3:0] t;
            logic [3:0] op4;
            bit take;
            string tag;
            string ptag;
            op4 = 4'(opc);
            t = 4'(opc * 5 + ri * 3 + f + e * 7);
            instr = {op4, t}; jmp = f[0]; en = e[0];
            take = (f == 1) || ((op4[3:2] == 2'b00) && (op4[1:0] == r));
            if (f == 1)               tag = "R10 forced";
            else if (opc == 0)        tag = "R5 opcode zero";
            else if (op4[3:2] != 0)   tag = "R4 nonzero prefix";
            else                      tag = "R3 branch decision";
            #1;
            chk(load_n == !take, tag, int'(load_n), int'(!take));
            tick;
            if (take)        begin exp_pc = t; ptag = "R1 R6 load target"; end
            else if (e == 1) begin exp_pc = exp_pc + 4'd1; ptag = "R7 increment"; end
            else             ptag = "R8 hold";
            chk(pc == exp_pc, ptag, int'(pc), int'(exp_pc));
          end
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule